// File: doc/BRIEF.md
# Flash Status Register Sequencer

This block turns a single request into the chain of chip-select frames that a serial NOR flash needs to read or change one of its three status registers. It does not move bits itself. Instead it sends one byte at a time to a byte shifter: it asserts a frame-select line, pulses a go strobe with the byte to transmit, and waits for an acknowledge that returns the byte clocked in. Between two frames the select line is dropped.

A request carries an operation code (read, write or quad enable), a register index from 1 to 3, write data and two quirk bits that are captured at start. One quirk drops the write-enable frame. The other quirk writes register 2 as a second data byte after register 1, with register 1 read back first, because some parts have no separate opcode for register 2. Quad enable is a read-modify-write of register 2 that sets its quad bit and keeps the other bits. A request with an unusable index or operation sends no frame. It finishes at once and raises an invalid flag.

Top module: `flash_status_seq`

## Requirements
- R1: A read of register 1 or 2 is one frame that starts with opcode 0x05. Register 1 is the first data byte and register 2 is the second data byte, so the frame is 2 or 3 bytes long. The byte clocked in at the last position is returned on `rd_val`. Bytes after the opcode are sent as 0xFF.
- R2: A read of register 3 is one frame of two bytes: opcode 0x15, then one data byte, which is returned on `rd_val`.
- R3: A status write (op 1) or a quad enable (op 2) begins its write part with a frame that holds only 0x06, unless `skip_wel` was high at start. In that case the frame is left out.
- R4: After the R3 step comes a frame that holds only 0x50. After it comes the data frame: 0x01 plus the value for register 1, or 0x11 plus the value for register 3.
- R5: When `sr2_combined` is low, register 2 is written with the data frame 0x31 plus the value. When it is high, the sequence starts with a register 1 read frame (0x05, 2 bytes). The data frame is then 0x01, the register 1 value just read, and the new value.
- R6: Quad enable (op 2, index ignored) reads register 2 with a 3-byte 0x05 frame. It returns the value read on `rd_val` and writes back that value with bit 1 set, following R3 to R5 for register 2.
- R7: `busy_flag` takes bit 0 of every register 1 byte received, which is data position 1 of any 0x05 frame. It keeps that value until the next such byte arrives. It is 0 after reset.
- R8: Register index 0 or op code 3 sends no frame. `done` and `bad_idx` are high together in the cycle after `start`, and `rd_val` becomes 0xFF.
- R9: `sh_go` is only asserted while `sh_sel` is high. After each go, it stays low until the acknowledge has been received. `sh_sel` stays low for at least one cycle between frames.
- R10: `done` is a one-cycle pulse that comes after the last frame has closed. A `start` that arrives while a request is running has no effect.
- R11: After reset, `done`, `bad_idx`, `busy_flag` and `sh_sel` are 0, and `rd_val` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when idle |
| op | input | 2 | 0 read, 1 write, 2 quad enable, 3 invalid |
| reg_sel | input | 2 | Status register index, 1 to 3 |
| wr_val | input | 8 | Value to write |
| skip_wel | input | 1 | Quirk: omit the 0x06 frame |
| sr2_combined | input | 1 | Quirk: write register 2 after register 1 in one frame |
| rd_val | output | 8 | Value read (0xFF after an invalid request) |
| done | output | 1 | One-cycle completion pulse |
| bad_idx | output | 1 | Invalid request, high together with done |
| busy_flag | output | 1 | Last seen bit 0 of register 1 |
| sh_sel | output | 1 | Frame select to the byte shifter |
| sh_go | output | 1 | Byte transfer strobe |
| sh_tx | output | 8 | Byte to transmit, valid with sh_go |
| sh_ack | input | 1 | Byte transfer finished |
| sh_rx | input | 8 | Byte received, valid with sh_ack |

## Verification
The bench builds the block with its default parameters: quad bit at position 1 and busy bit at position 0. With these values the set bit and the busy reading land on the bit positions named in R6 and R7. The shifter model in the bench has a selectable acknowledge latency. The suite runs once with a one-cycle latency and again with four cycles, so that the back-to-back handshake and the long wait between go and acknowledge are both covered. Every scenario checks the exact byte content and length of each logged frame, and the register values the flash model ends up holding.

// File: rtl/flash_sts_pkg.sv
// Shared types for the flash status sequencer.
// Assumes: byte-wide shifter, status registers numbered 1..3.
package flash_sts_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_QUAD  = 2'd2,
        OP_BAD   = 2'd3
    } sts_op_e;

    typedef enum logic [1:0] {
        PH_READ  = 2'd0,
        PH_WREN  = 2'd1,
        PH_VOLEN = 2'd2,
        PH_WRITE = 2'd3
    } sts_phase_e;

    localparam logic [7:0] CMD_RD12  = 8'h05;
    localparam logic [7:0] CMD_RD3   = 8'h15;
    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_VOLEN = 8'h50;
    localparam logic [7:0] CMD_WR1   = 8'h01;
    localparam logic [7:0] CMD_WR2   = 8'h31;
    localparam logic [7:0] CMD_WR3   = 8'h11;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

endpackage

// File: rtl/flash_sts_frame_map.sv
// Frame content map: gives the byte to send at each position, and the
// frame length, for the current phase.
// Assumes: inputs stay stable for the whole frame.
module flash_sts_frame_map
    import flash_sts_pkg::*;
#(
    parameter int DW = 8,
    parameter int PW = 2
) (
    input  sts_phase_e      phase,
    input  logic [1:0]      rd_reg,
    input  logic [1:0]      wr_reg,
    input  logic            combined,
    input  logic [DW-1:0]   sr1_saved,
    input  logic [DW-1:0]   new_val,
    input  logic [PW-1:0]   pos,
    output logic [DW-1:0]   tx_byte,
    output logic [PW-1:0]   frame_len
);

    // Choose the byte and the frame length from phase and position.
    always_comb begin
        tx_byte   = FILL_BYTE;
        frame_len = PW'(1);
        unique case (phase)
            PH_READ: begin
                frame_len = (rd_reg == 2'd2) ? PW'(3) : PW'(2);
                if (pos == '0)
                    tx_byte = (rd_reg == 2'd3) ? CMD_RD3 : CMD_RD12;
            end
            PH_WREN:  tx_byte = CMD_WREN;
            PH_VOLEN: tx_byte = CMD_VOLEN;
            PH_WRITE: begin
                if (combined && wr_reg == 2'd2) begin
                    frame_len = PW'(3);
                    if (pos == '0)      tx_byte = CMD_WR1;
                    else if (pos == 1)  tx_byte = sr1_saved;
                    else                tx_byte = new_val;
                end else begin
                    frame_len = PW'(2);
                    if (pos == '0)
                        tx_byte = (wr_reg == 2'd1) ? CMD_WR1 :
                                  (wr_reg == 2'd2) ? CMD_WR2 : CMD_WR3;
                    else
                        tx_byte = new_val;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/flash_sts_byte_engine.sv
// Byte engine: opens a frame, hands one byte at a time to the shifter,
// then closes the frame and keeps select low for one gap cycle.
// Assumes: the shifter acknowledges every go exactly once.
module flash_sts_byte_engine #(
    parameter int DW = 8,
    parameter int PW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_go,
    input  logic [PW-1:0]   frame_len,
    output logic [PW-1:0]   pos,
    output logic            rx_valid,
    output logic            frame_done,
    output logic            sh_sel,
    output logic            sh_go,
    input  logic            sh_ack
);

    typedef enum logic [1:0] {E_OFF, E_ISSUE, E_WAIT, E_GAP} eng_e;
    eng_e st_q;

    // Step through issue, wait and gap for each byte of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= E_OFF;
            pos    <= '0;
            sh_sel <= 1'b0;
        end else begin
            unique case (st_q)
                E_OFF: if (frame_go) begin
                    sh_sel <= 1'b1;
                    pos    <= '0;
                    st_q   <= E_ISSUE;
                end
                E_ISSUE: st_q <= E_WAIT;
                E_WAIT: if (sh_ack) begin
                    if (pos == frame_len - PW'(1)) begin
                        sh_sel <= 1'b0;
                        st_q   <= E_GAP;
                    end else begin
                        pos  <= pos + PW'(1);
                        st_q <= E_ISSUE;
                    end
                end
                E_GAP: st_q <= E_OFF;
                default: st_q <= E_OFF;
            endcase
        end
    end

    // Strobes seen by the shifter and by the sequencer.
    assign sh_go      = (st_q == E_ISSUE);
    assign rx_valid   = (st_q == E_WAIT) && sh_ack;
    assign frame_done = (st_q == E_GAP);

endmodule

// File: rtl/flash_status_seq.sv
// Status register sequencer: decodes a request into a chain of frames
// (read, write enable, volatile enable, data write) and moves through them.
// Assumes: quirk bits and request fields are sampled only at start.
module flash_status_seq
    import flash_sts_pkg::*;
#(
    parameter int DW       = 8,
    parameter int QE_BIT   = 1,
    parameter int BUSY_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [1:0]      reg_sel,
    input  logic [DW-1:0]   wr_val,
    input  logic            skip_wel,
    input  logic            sr2_combined,
    output logic [DW-1:0]   rd_val,
    output logic            done,
    output logic            bad_idx,
    output logic            busy_flag,
    output logic            sh_sel,
    output logic            sh_go,
    output logic [DW-1:0]   sh_tx,
    input  logic            sh_ack,
    input  logic [DW-1:0]   sh_rx
);

    localparam int PW = 2;
    localparam logic [DW-1:0] QE_MASK = DW'(1) << QE_BIT;

    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_RUN, S_FIN} seq_e;

    seq_e            st_q;
    sts_phase_e      ph_q;
    sts_op_e         op_q;
    logic [1:0]      idx_q;
    logic            skip_q, comb_q, pre_q, bad_q;
    logic [DW-1:0]   val_q, sr1_q;
    logic [1:0]      rd_reg, wr_reg;
    logic [PW-1:0]   pos, frame_len;
    logic            rx_valid, frame_done;
    logic [PW-1:0]   last_pos;

    // Register read by a read frame, and register written by a write frame.
    assign rd_reg   = pre_q ? 2'd1 : (op_q == OP_QUAD) ? 2'd2 : idx_q;
    assign wr_reg   = (op_q == OP_QUAD) ? 2'd2 : idx_q;
    assign last_pos = frame_len - PW'(1);

    flash_sts_frame_map #(.DW(DW), .PW(PW)) u_map (
        .phase     (ph_q),
        .rd_reg    (rd_reg),
        .wr_reg    (wr_reg),
        .combined  (comb_q),
        .sr1_saved (sr1_q),
        .new_val   (val_q),
        .pos       (pos),
        .tx_byte   (sh_tx),
        .frame_len (frame_len)
    );

    flash_sts_byte_engine #(.DW(DW), .PW(PW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_go   (st_q == S_LAUNCH),
        .frame_len  (frame_len),
        .pos        (pos),
        .rx_valid   (rx_valid),
        .frame_done (frame_done),
        .sh_sel     (sh_sel),
        .sh_go      (sh_go),
        .sh_ack     (sh_ack)
    );

    // Request decode and phase chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            ph_q   <= PH_READ;
            op_q   <= OP_READ;
            idx_q  <= 2'd1;
            skip_q <= 1'b0;
            comb_q <= 1'b0;
            pre_q  <= 1'b0;
            bad_q  <= 1'b0;
            val_q  <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start) begin
                    op_q   <= sts_op_e'(op);
                    idx_q  <= reg_sel;
                    val_q  <= wr_val;
                    skip_q <= skip_wel;
                    comb_q <= sr2_combined;
                    pre_q  <= 1'b0;
                    bad_q  <= 1'b0;
                    if (sts_op_e'(op) == OP_BAD || (reg_sel == 2'd0 && sts_op_e'(op) != OP_QUAD)) begin
                        bad_q <= 1'b1;
                        st_q  <= S_FIN;
                    end else if (sts_op_e'(op) == OP_WRITE) begin
                        st_q <= S_LAUNCH;
                        if (reg_sel == 2'd2 && sr2_combined) begin
                            pre_q <= 1'b1;
                            ph_q  <= PH_READ;
                        end else begin
                            ph_q <= skip_wel ? PH_VOLEN : PH_WREN;
                        end
                    end else begin
                        ph_q <= PH_READ;
                        st_q <= S_LAUNCH;
                    end
                end
                S_LAUNCH: st_q <= S_RUN;
                S_RUN: begin
                    if (rx_valid && ph_q == PH_READ && pos == last_pos
                        && !pre_q && op_q == OP_QUAD)
                        val_q <= sh_rx | QE_MASK;
                    if (frame_done) begin
                        st_q <= S_LAUNCH;
                        unique case (ph_q)
                            PH_READ: begin
                                if (!pre_q && op_q == OP_READ) begin
                                    st_q <= S_FIN;
                                end else if (!pre_q && comb_q) begin
                                    pre_q <= 1'b1;
                                end else begin
                                    ph_q <= skip_q ? PH_VOLEN : PH_WREN;
                                end
                            end
                            PH_WREN:  ph_q <= PH_VOLEN;
                            PH_VOLEN: ph_q <= PH_WRITE;
                            PH_WRITE: st_q <= S_FIN;
                            default:  st_q <= S_FIN;
                        endcase
                    end
                end
                S_FIN: st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Capture of read results, saved register 1 and the busy bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_val    <= '1;
            sr1_q     <= '0;
            busy_flag <= 1'b0;
        end else if (st_q == S_IDLE && start && (sts_op_e'(op) == OP_BAD ||
                     (reg_sel == 2'd0 && sts_op_e'(op) != OP_QUAD))) begin
            rd_val <= '1;
        end else if (rx_valid && ph_q == PH_READ) begin
            if (pos == PW'(1) && rd_reg != 2'd3)
                busy_flag <= sh_rx[BUSY_BIT];
            if (pos == last_pos) begin
                if (pre_q) sr1_q  <= sh_rx;
                else       rd_val <= sh_rx;
            end
        end
    end

    // Completion outputs.
    assign done    = (st_q == S_FIN);
    assign bad_idx = (st_q == S_FIN) && bad_q;

endmodule

// File: rtl/flash_status_seq_chk.sv
// Port-level checker for the status sequencer; bound to every instance.
// Assumes: synchronous active-low reset.
module flash_status_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic done,
    input logic bad_idx,
    input logic sh_sel,
    input logic sh_go,
    input logic sh_ack
);

    AST_GO_IN_FRAME:   assert property (@(posedge clk) disable iff (!rst_n) sh_go |-> sh_sel);               // R9
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) sh_go |=> !sh_go);               // R9
    AST_SEL_GAP:       assert property (@(posedge clk) disable iff (!rst_n) $fell(sh_sel) |=> !sh_sel);      // R9
    AST_NO_GO_ON_ACK:  assert property (@(posedge clk) disable iff (!rst_n) sh_ack |-> !sh_go);              // R9
    AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                 // R10
    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !sh_sel);               // R10
    AST_BAD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) bad_idx |-> done);               // R8
    AST_BAD_NO_FRAME:  assert property (@(posedge clk) disable iff (!rst_n) bad_idx |-> $stable(sh_sel) && !sh_sel); // R8

endmodule

bind flash_status_seq flash_status_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .bad_idx (bad_idx),
    .sh_sel  (sh_sel),
    .sh_go   (sh_go),
    .sh_ack  (sh_ack)
);

// File: tb/flash_status_seq_tb.sv
// Directed bench: a behavioural shifter plus flash model logs every frame.
module flash_status_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [1:0] reg_sel = 2'd1;
    logic [7:0] wr_val = 8'h00;
    logic       skip_wel = 1'b0;
    logic       sr2_combined = 1'b0;
    logic [7:0] rd_val;
    logic       done, bad_idx, busy_flag, sh_sel, sh_go;
    logic [7:0] sh_tx;
    logic       sh_ack = 1'b0;
    logic [7:0] sh_rx = 8'h00;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    flash_status_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reg_sel(reg_sel),
        .wr_val(wr_val), .skip_wel(skip_wel), .sr2_combined(sr2_combined),
        .rd_val(rd_val), .done(done), .bad_idx(bad_idx), .busy_flag(busy_flag),
        .sh_sel(sh_sel), .sh_go(sh_go), .sh_tx(sh_tx), .sh_ack(sh_ack), .sh_rx(sh_rx)
    );

    // Flash and shifter model.
    logic [7:0] m_sr1 = 8'h00, m_sr2 = 8'h00, m_sr3 = 8'h00;
    logic [7:0] flog [128][3];
    int         flen [128];
    int         nfr = 0;
    int         lat = 1;
    int         cnt = 0;
    int         pos = 0;
    logic       in_fr = 1'b0;
    logic [7:0] resp = 8'hFF;

    always @(posedge clk) begin
        sh_ack <= 1'b0;
        if (cnt > 0) begin
            cnt = cnt - 1;
            if (cnt == 0) begin
                sh_ack <= 1'b1;
                sh_rx  <= resp;
            end
        end
        if (!sh_sel && in_fr) begin
            in_fr = 1'b0;
            case (flog[nfr-1][0])
                8'h01: begin
                    if (flen[nfr-1] >= 2) m_sr1 = flog[nfr-1][1];
                    if (flen[nfr-1] >= 3) m_sr2 = flog[nfr-1][2];
                end
                8'h31: m_sr2 = flog[nfr-1][1];
                8'h11: m_sr3 = flog[nfr-1][1];
                default: ;
            endcase
        end
        if (sh_go && nfr < 128) begin
            if (!in_fr) begin
                in_fr = 1'b1;
                nfr = nfr + 1;
                pos = 0;
            end
            if (pos < 3) flog[nfr-1][pos] = sh_tx;
            resp = 8'hFF;
            if (pos > 0 && flog[nfr-1][0] == 8'h05)
                resp = (pos == 1) ? m_sr1 : (pos == 2) ? m_sr2 : 8'hFF;
            if (pos == 1 && flog[nfr-1][0] == 8'h15)
                resp = m_sr3;
            pos = pos + 1;
            flen[nfr-1] = pos;
            cnt = lat;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_frame(input string tag, input int f, input int len,
                             input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        chk({tag, " len"}, flen[f], len);
        chk({tag, " b0"}, flog[f][0], b0);
        if (len > 1) chk({tag, " b1"}, flog[f][1], b1);
        if (len > 2) chk({tag, " b2"}, flog[f][2], b2);
    endtask

    // Issue one request, wait for done, return bad flag and frame base.
    task automatic run_op(input logic [1:0] o, input logic [1:0] r, input logic [7:0] v,
                          input logic sk, input logic cb, output logic bad, output int base);
        int n;
        base = nfr;
        @(negedge clk);
        op = o; reg_sel = r; wr_val = v; skip_wel = sk; sr2_combined = cb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        bad = bad_idx;
        chk("R10 done seen", done, 1'b1);
        @(negedge clk);
        chk("R10 done one cycle", done, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 done", done, 1'b0);
        chk("R11 bad", bad_idx, 1'b0);
        chk("R11 busy", busy_flag, 1'b0);
        chk("R11 sel", sh_sel, 1'b0);
        chk("R11 rd_val", rd_val, 8'hFF);
    endtask

    task automatic t_reads;
        logic b; int f;
        m_sr1 = 8'h5C; m_sr2 = 8'hA3; m_sr3 = 8'h71;
        run_op(2'd0, 2'd1, 8'h00, 1'b0, 1'b0, b, f);
        chk("R1 reg1 frames", nfr - f, 1);
        chk_frame("R1 reg1", f, 2, 8'h05, 8'hFF, 8'h00);
        chk("R1 reg1 value", rd_val, 8'h5C);
        run_op(2'd0, 2'd2, 8'h00, 1'b0, 1'b0, b, f);
        chk_frame("R1 reg2", f, 3, 8'h05, 8'hFF, 8'hFF);
        chk("R1 reg2 value", rd_val, 8'hA3);
        run_op(2'd0, 2'd3, 8'h00, 1'b0, 1'b0, b, f);
        chk_frame("R2 reg3", f, 2, 8'h15, 8'hFF, 8'h00);
        chk("R2 reg3 value", rd_val, 8'h71);
        chk("R2 no bad", b, 1'b0);
    endtask

    task automatic t_busy;
        logic b; int f;
        m_sr1 = 8'h01; m_sr2 = 8'h00;
        run_op(2'd0, 2'd1, 8'h00, 1'b0, 1'b0, b, f);
        chk("R7 busy set by reg1 read", busy_flag, 1'b1);
        m_sr1 = 8'hFE;
        run_op(2'd0, 2'd3, 8'h00, 1'b0, 1'b0, b, f);
        chk("R7 reg3 read keeps busy", busy_flag, 1'b1);
        run_op(2'd0, 2'd2, 8'h00, 1'b0, 1'b0, b, f);
        chk("R7 busy cleared by reg2 frame", busy_flag, 1'b0);
    endtask

    task automatic t_write13;
        logic b; int f;
        m_sr1 = 8'h00; m_sr3 = 8'h00;
        run_op(2'd1, 2'd1, 8'h3C, 1'b0, 1'b0, b, f);
        chk("R3 frames with wren", nfr - f, 3);
        chk_frame("R3 wren", f, 1, 8'h06, 8'h00, 8'h00);
        chk_frame("R4 volen", f + 1, 1, 8'h50, 8'h00, 8'h00);
        chk_frame("R4 wr1", f + 2, 2, 8'h01, 8'h3C, 8'h00);
        chk("R4 reg1 stored", m_sr1, 8'h3C);
        run_op(2'd1, 2'd3, 8'h9A, 1'b1, 1'b0, b, f);
        chk("R3 skip frames", nfr - f, 2);
        chk_frame("R4 volen skip", f, 1, 8'h50, 8'h00, 8'h00);
        chk_frame("R4 wr3", f + 1, 2, 8'h11, 8'h9A, 8'h00);
        chk("R4 reg3 stored", m_sr3, 8'h9A);
    endtask

    task automatic t_write2;
        logic b; int f;
        m_sr1 = 8'h44; m_sr2 = 8'h00;
        run_op(2'd1, 2'd2, 8'h66, 1'b0, 1'b0, b, f);
        chk("R5 separate frames", nfr - f, 3);
        chk_frame("R5 wr2 separate", f + 2, 2, 8'h31, 8'h66, 8'h00);
        chk("R5 reg2 stored", m_sr2, 8'h66);
        m_sr1 = 8'h28;
        run_op(2'd1, 2'd2, 8'h0F, 1'b1, 1'b1, b, f);
        chk("R5 combined frames", nfr - f, 3);
        chk_frame("R5 pre-read", f, 2, 8'h05, 8'hFF, 8'h00);
        chk_frame("R5 volen", f + 1, 1, 8'h50, 8'h00, 8'h00);
        chk_frame("R5 combined write", f + 2, 3, 8'h01, 8'h28, 8'h0F);
        chk("R5 reg1 kept", m_sr1, 8'h28);
        chk("R5 reg2 combined stored", m_sr2, 8'h0F);
    endtask

    task automatic t_quad;
        logic b; int f;
        m_sr1 = 8'h10; m_sr2 = 8'h41;
        run_op(2'd2, 2'd0, 8'h00, 1'b0, 1'b0, b, f);
        chk("R6 frames", nfr - f, 4);
        chk_frame("R6 read", f, 3, 8'h05, 8'hFF, 8'hFF);
        chk_frame("R6 wren", f + 1, 1, 8'h06, 8'h00, 8'h00);
        chk_frame("R6 write", f + 3, 2, 8'h31, 8'h43, 8'h00);
        chk("R6 rd_val old", rd_val, 8'h41);
        chk("R6 reg2", m_sr2, 8'h43);
        chk("R6 index ignored", b, 1'b0);
        m_sr1 = 8'h81; m_sr2 = 8'hF2;
        run_op(2'd2, 2'd3, 8'h00, 1'b1, 1'b1, b, f);
        chk("R6 combined frames", nfr - f, 4);
        chk_frame("R6 combined pre-read", f + 1, 2, 8'h05, 8'hFF, 8'h00);
        chk_frame("R6 combined write", f + 3, 3, 8'h01, 8'h81, 8'hF2);
        chk("R6 bit already set", m_sr2, 8'hF2);
        chk("R7 busy from quad reads", busy_flag, 1'b1);
    endtask

    task automatic t_bad;
        logic b; int f;
        m_sr1 = 8'h12;
        run_op(2'd0, 2'd1, 8'h00, 1'b0, 1'b0, b, f);
        run_op(2'd0, 2'd0, 8'h00, 1'b0, 1'b0, b, f);
        chk("R8 bad flag index 0", b, 1'b1);
        chk("R8 no frames", nfr - f, 0);
        chk("R8 rd_val FF", rd_val, 8'hFF);
        run_op(2'd3, 2'd1, 8'h55, 1'b0, 1'b0, b, f);
        chk("R8 bad flag op 3", b, 1'b1);
        chk("R8 no frames op 3", nfr - f, 0);
        run_op(2'd1, 2'd0, 8'h55, 1'b0, 1'b0, b, f);
        chk("R8 write index 0", b, 1'b1);
        chk("R8 reg1 untouched", m_sr1, 8'h12);
    endtask

    task automatic t_busy_start;
        int f, n;
        m_sr3 = 8'h00; m_sr1 = 8'h77;
        f = nfr;
        @(negedge clk);
        op = 2'd1; reg_sel = 2'd3; wr_val = 8'hB4; skip_wel = 1'b0; sr2_combined = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op = 2'd1; reg_sel = 2'd1; wr_val = 8'h00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
        chk("R10 ignored start frames", nfr - f, 3);
        chk("R10 reg3 from first request", m_sr3, 8'hB4);
        chk("R10 reg1 untouched", m_sr1, 8'h77);
    endtask

    task automatic suite;
        t_reads();
        t_busy();
        t_write13();
        t_write2();
        t_quad();
        t_bad();
        t_busy_start();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        lat = 1;
        suite();
        lat = 4;
        suite();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R10: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule